// File: doc/BRIEF.md
# I2C Control and Status Register

This block holds the control and status byte of a multi-master I2C controller, as seen from a CPU register port with separate write and read strobes. Software uses it to choose one of four transfer modes, gate the serial data output, and command start and stop conditions. Writes to the busy position are not stored. Each write becomes a one-cycle command pulse to the bus engine. A start command also tells the engine to load and send its data byte straight after the start condition.

The bus engine reports events back as single-cycle strobes: start seen, stop seen, arbitration lost, own address matched, all-zero address received, and a sampled acknowledge bit. The block turns these into sticky status flags. Each flag has its own clear rule. When a flag's set event and its clear condition land in the same cycle, the set wins.

Top module: `i2c_ctlstat`

## Requirements
- R1: After reset the read value is 0x00, `mode` is 0, `tx_out_en` is 0, and no command pulse is active.
- R2: A write stores bits [7:6] as the mode (00 slave receive, 01 slave transmit, 10 master receive, 11 master transmit). The mode reads back at [7:6] and appears on `mode` from the cycle after the write.
- R3: A write with bit 5 = 1 makes `cmd_start` and `cmd_load_tx` high together for exactly the one cycle after the write.
- R4: A write with bit 5 = 0 makes `cmd_stop` high for exactly the one cycle after the write. `cmd_start` and `cmd_stop` are never high together.
- R5: Read bit 5 (busy) becomes 1 the cycle after `ev_start_det` and 0 the cycle after `ev_stop_det`. Writes never change it.
- R6: Bit 4 written as 1 enables the serial output: it reads back at bit 4 and drives `tx_out_en`.
- R7: Read bit 3 becomes 1 after `ev_arb_lost` and returns to 0 after the next `ev_start_det`.
- R8: Read bit 2 becomes 1 after `ev_addr_match`. A read returns the flag and clears it for the following cycle.
- R9: Read bit 1 becomes 1 after `ev_addr_zero` and is cleared by `ev_start_det` or `ev_stop_det`.
- R10: Read bit 0 takes the value of `ev_rx_bit` in the cycle after `ev_rx_bit_vld` (0 = acknowledge, 1 = no acknowledge), and holds it otherwise.
- R11: When a flag's set event and its clear condition occur in the same cycle, the flag ends up set. If start and stop are seen together, busy ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Current register value |
| ev_start_det | input | 1 | Engine saw a START condition |
| ev_stop_det | input | 1 | Engine saw a STOP condition |
| ev_arb_lost | input | 1 | Engine lost arbitration |
| ev_addr_match | input | 1 | Received address equals own address |
| ev_addr_zero | input | 1 | Received address is all zeros |
| ev_rx_bit_vld | input | 1 | Last received bit is valid this cycle |
| ev_rx_bit | input | 1 | Value of the last received bit |
| mode | output | 2 | Selected transfer mode |
| tx_out_en | output | 1 | Serial output enable |
| cmd_start | output | 1 | Request START condition (one cycle) |
| cmd_stop | output | 1 | Request STOP condition (one cycle) |
| cmd_load_tx | output | 1 | Load and send data byte after START |

## Verification
The properties assume that every engine event is a one-cycle strobe sampled on the rising clock edge. They also assume that `ev_rx_bit` is only meaningful while `ev_rx_bit_vld` is high. Read and write strobes may coincide with any event. The bench drives all inputs just after a rising edge and holds each strobe for one cycle only. It samples outputs on the falling edge. It deliberately stacks set events on clear conditions to reach the conflicting cases.

// File: rtl/i2c_cs_pkg.sv
package i2c_cs_pkg;
  localparam int REG_W     = 8;
  localparam int MODE_LSB  = 6;
  localparam int BUSY_BIT  = 5;
  localparam int OEN_BIT   = 4;
  localparam int ARB_BIT   = 3;
  localparam int MATCH_BIT = 2;
  localparam int ZERO_BIT  = 1;
  localparam int RXB_BIT   = 0;

  localparam int NFLAG     = 5;
  localparam int FL_BUSY   = 0;
  localparam int FL_ARB    = 1;
  localparam int FL_MATCH  = 2;
  localparam int FL_ZERO   = 3;
  localparam int FL_RXB    = 4;

  typedef enum logic [1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/i2c_cs_flag.sv
module i2c_cs_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  // set dominates a simultaneous clear
  always_comb begin
    q_en = set_i | clr_i;
    q_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (q_en)  q_o <= q_d;
  end
endmodule

// File: rtl/i2c_cs_cfg.sv
module i2c_cs_cfg
  import i2c_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output xfer_mode_e       mode_o,
  output logic             oen_o
);
  xfer_mode_e mode_d;
  logic       oen_d;

  always_comb begin
    mode_d = xfer_mode_e'(wr_data[MODE_LSB +: 2]);
    oen_d  = wr_data[OEN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o <= MODE_SLV_RX;
      oen_o  <= 1'b0;
    end else if (wr_en) begin
      mode_o <= mode_d;
      oen_o  <= oen_d;
    end
  end
endmodule

// File: rtl/i2c_cs_cmd.sv
module i2c_cs_cmd
  import i2c_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic             start_o,
  output logic             stop_o
);
  logic start_d;
  logic stop_d;

  always_comb begin
    start_d = wr_en &  wr_data[BUSY_BIT];
    stop_d  = wr_en & ~wr_data[BUSY_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      start_o <= start_d;
      stop_o  <= stop_d;
    end
  end
endmodule

// File: rtl/i2c_ctlstat.sv
module i2c_ctlstat
  import i2c_cs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             ev_start_det,
  input  logic             ev_stop_det,
  input  logic             ev_arb_lost,
  input  logic             ev_addr_match,
  input  logic             ev_addr_zero,
  input  logic             ev_rx_bit_vld,
  input  logic             ev_rx_bit,
  output logic [1:0]       mode,
  output logic             tx_out_en,
  output logic             cmd_start,
  output logic             cmd_stop,
  output logic             cmd_load_tx
);
  xfer_mode_e       mode_q;
  logic [NFLAG-1:0] fl_set;
  logic [NFLAG-1:0] fl_clr;
  logic [NFLAG-1:0] fl_q;
  logic             start_q;

  i2c_cs_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .mode_o(mode_q), .oen_o(tx_out_en)
  );

  i2c_cs_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .start_o(start_q), .stop_o(cmd_stop)
  );

  // per-flag set and clear rules
  always_comb begin
    fl_set           = '0;
    fl_clr           = '0;
    fl_set[FL_BUSY]  = ev_start_det;
    fl_clr[FL_BUSY]  = ev_stop_det;
    fl_set[FL_ARB]   = ev_arb_lost;
    fl_clr[FL_ARB]   = ev_start_det;
    fl_set[FL_MATCH] = ev_addr_match;
    fl_clr[FL_MATCH] = rd_en;
    fl_set[FL_ZERO]  = ev_addr_zero;
    fl_clr[FL_ZERO]  = ev_start_det | ev_stop_det;
    fl_set[FL_RXB]   = ev_rx_bit_vld &  ev_rx_bit;
    fl_clr[FL_RXB]   = ev_rx_bit_vld & ~ev_rx_bit;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    i2c_cs_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set_i(fl_set[g]), .clr_i(fl_clr[g]), .q_o(fl_q[g])
    );
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[MODE_LSB +: 2]   = mode_q;
    rd_data[BUSY_BIT]        = fl_q[FL_BUSY];
    rd_data[OEN_BIT]         = tx_out_en;
    rd_data[ARB_BIT]         = fl_q[FL_ARB];
    rd_data[MATCH_BIT]       = fl_q[FL_MATCH];
    rd_data[ZERO_BIT]        = fl_q[FL_ZERO];
    rd_data[RXB_BIT]         = fl_q[FL_RXB];
    mode                     = mode_q;
    cmd_start                = start_q;
    cmd_load_tx              = start_q;
  end
endmodule

// File: rtl/i2c_ctlstat_chk.sv
module i2c_ctlstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       ev_start_det,
  input logic       ev_stop_det,
  input logic       ev_arb_lost,
  input logic       ev_addr_match,
  input logic       ev_addr_zero,
  input logic       ev_rx_bit_vld,
  input logic       ev_rx_bit,
  input logic [1:0] mode,
  input logic       cmd_start,
  input logic       cmd_stop,
  input logic       cmd_load_tx
);
  // R3
  start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[5] |=> cmd_start && cmd_load_tx);
  // R4
  stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_data[5] |=> cmd_stop);
  // R4
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_start, cmd_stop}));
  // R3
  no_spurious_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !cmd_start && !cmd_stop);
  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mode));
  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_det |=> rd_data[5]);
  // R5
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_det && !ev_start_det |=> !rd_data[5]);
  // R7
  arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> rd_data[3]);
  // R8
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_match |=> rd_data[2]);
  // R8
  match_rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !ev_addr_match |=> !rd_data[2]);
  // R9
  zero_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_zero |=> rd_data[1]);
  // R9
  zero_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_start_det || ev_stop_det) && !ev_addr_zero |=> !rd_data[1]);
  // R10
  rxbit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_bit_vld |=> rd_data[0] == $past(ev_rx_bit));
endmodule

bind i2c_ctlstat i2c_ctlstat_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .ev_start_det(ev_start_det),
  .ev_stop_det(ev_stop_det), .ev_arb_lost(ev_arb_lost),
  .ev_addr_match(ev_addr_match), .ev_addr_zero(ev_addr_zero),
  .ev_rx_bit_vld(ev_rx_bit_vld), .ev_rx_bit(ev_rx_bit), .mode(mode),
  .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_load_tx(cmd_load_tx)
);

// File: tb/sim_i2c_ctlstat.sv
module sim_i2c_ctlstat;
  localparam time CLK_P = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       ev_start_det = 0, ev_stop_det = 0, ev_arb_lost = 0;
  logic       ev_addr_match = 0, ev_addr_zero = 0, ev_rx_bit_vld = 0, ev_rx_bit = 0;
  logic [1:0] mode;
  logic       tx_out_en, cmd_start, cmd_stop, cmd_load_tx;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c_ctlstat u0 (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read value when a read is presented
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_q.size() == 0) check("scoreboard underflow", 8'h00, 8'hff);
      else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
    end
  end

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  // ev = {start, stop, arb, match, zero, rxvld}
  task automatic evt(input logic [5:0] ev, input logic rxb);
    {ev_start_det, ev_stop_det, ev_arb_lost, ev_addr_match, ev_addr_zero, ev_rx_bit_vld} = ev;
    ev_rx_bit = rxb;
  endtask

  task automatic rd(input logic [7:0] exp, input string tag, input logic [5:0] ev = 6'b0);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; evt(ev, 1'b0);
    nxt();
    rd_en = 1'b0; evt(6'b0, 1'b0);
  endtask

  task automatic ev1(input logic [5:0] ev, input logic rxb = 1'b0);
    evt(ev, rxb); nxt(); evt(6'b0, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    wr_en = 1'b1; wr_data = d;
    nxt();
    wr_en = 1'b0;
    @(negedge clk);
    check({tag, " cmd_start"}, {7'b0, cmd_start}, {7'b0, d[5]});
    check({tag, " cmd_load_tx"}, {7'b0, cmd_load_tx}, {7'b0, d[5]});
    check({tag, " cmd_stop"}, {7'b0, cmd_stop}, {7'b0, ~d[5]});
    nxt();
    @(negedge clk);
    check({tag, " pulse ends"}, {6'b0, cmd_start, cmd_stop}, 8'h00);
    nxt();
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P*3); nxt(); rst_n = 1'b1; nxt();
    @(negedge clk);
    // R1 reset state
    check("R1 mode", {6'b0, mode}, 8'h00);
    check("R1 outputs", {4'b0, tx_out_en, cmd_start, cmd_stop, cmd_load_tx}, 8'h00);
    nxt();
    rd(8'h00, "R1 reset read");
    // R2 R4 R6: master transmit, enabled, stop command
    wr(8'hD0, "R4 stop write");
    rd(8'hD0, "R2 R6 readback");
    @(negedge clk);
    check("R2 mode port", {6'b0, mode}, 8'h03);
    check("R6 tx_out_en", {7'b0, tx_out_en}, 8'h01);
    nxt();
    // R3 R5: start command does not set busy
    wr(8'hF0, "R3 start write");
    rd(8'hD0, "R5 write leaves busy");
    ev1(6'b100000);
    rd(8'hF0, "R5 busy set");
    ev1(6'b001000);
    rd(8'hF8, "R7 arb set");
    ev1(6'b000100);
    rd(8'hFC, "R8 match set");
    rd(8'hF8, "R8 cleared by read");
    ev1(6'b000010);
    rd(8'hFA, "R9 zero set");
    ev1(6'b000001, 1'b1);
    rd(8'hFB, "R10 nack latched");
    rd(8'hFB, "R10 holds");
    ev1(6'b000001, 1'b0);
    rd(8'hFA, "R10 ack latched");
    ev1(6'b010000);
    rd(8'hD8, "R5 R9 stop clears busy and zero");
    ev1(6'b100000);
    rd(8'hF0, "R7 start clears arb");
    // R11 conflicts
    rd(8'hF0, "R11 read with match", 6'b000100);
    rd(8'hF4, "R11 match survives read");
    rd(8'hF0, "R8 second read clears");
    ev1(6'b010010);
    rd(8'hD2, "R11 zero set beats stop");
    ev1(6'b110000);
    rd(8'hF0, "R11 start beats stop");
    ev1(6'b101000);
    rd(8'hF8, "R11 arb set beats start");
    // R2 R6 other mode, output disabled
    wr(8'h40, "R4 stop write 2");
    rd(8'h68, "R2 slave tx readback");
    @(negedge clk);
    check("R2 mode slave tx", {6'b0, mode}, 8'h01);
    check("R6 disabled", {7'b0, tx_out_en}, 8'h00);
    nxt(); nxt();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule